// File: doc/BRIEF.md
# Configuration port unlock controller

This block gives a host a byte-wide window onto a set of configuration registers through two I/O ports: an index port (address bit 0 = 0, the even port at 0x2E) and a data port (address bit 0 = 1, the odd port at 0x2F). Access starts out locked. The host opens it by writing a four-byte key to the index port.

Once access is open, the host writes a register number to the index port. It then reads or writes that register through the data port. A logical-device number register picks one of three device banks. Each bank has an activate bit and a 16-bit base address, and all three banks answer at the same indexes. Two global registers report a chip ID and a revision.

The activate bits and base addresses of the three banks are driven out as plain outputs, for use by the devices they configure.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the block is locked, the logical-device number is 0x00, every activate bit is 0 and every base address is 0x0000.
- R2: Index-port writes of 0x87, 0x01, 0x55, 0x55, in that order, open configuration access on the clock edge that takes the last byte.
- R3: While locked, an index-port byte that does not match the next expected key byte restarts key matching. If that byte is 0x87, it counts as the first key byte.
- R4: While locked, data-port writes change nothing, and reads of either port return 0xFF.
- R5: While open, an index-port write stores the byte as the current index, and an index-port read returns it.
- R6: While open, writing 0x02 through the data port while the index is 0x02 locks the block again. Any other value written at index 0x02 leaves it open.
- R7: Index 0x07 holds the logical-device number and can be read and written through the data port.
- R8: Index 0x20 reads the chip ID high byte and index 0x21 reads the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 zero.
- R9: Index 0x30 is the activate bit (data bit 0) of the selected bank. Reads return it in bit 0 with bits 7:1 zero. Device 0x07 drives dev_act[0], device 0x09 drives dev_act[1], and device 0x0A drives dev_act[2].
- R10: Index 0x60 holds the selected bank's base address high byte and index 0x61 holds the low byte. Bank k drives dev_base[16k+15:16k].
- R11: When the logical-device number names none of the three banks, writes to 0x30, 0x60 and 0x61 are ignored and those indexes read 0x00. Indexes with no register read 0x00.
- R12: io_rdata shows the addressed value in the same cycle io_rd is high, and it is 0x00 while io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 1 | Port select: 0 index, 1 data |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte |
| dev_act | output | 3 | Activate bits of the three banks |
| dev_base | output | 48 | Base addresses of the three banks, 16 bits each |

## Verification
The assertions assume that io_wr and io_rd are never high in the same cycle, and that each strobe lasts one cycle per byte transfer. The bench drives exactly one operation per two clock cycles and never overlaps the strobes. Random stimulus is biased toward key bytes, the defined indexes and the three bank numbers. This makes unlock, relock and bank switching happen many times within a few thousand operations.

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock #(
  parameter logic [15:0] CHIP_ID  = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV = 4'h3,
  parameter logic [7:0]  LDN_A    = 8'h07,
  parameter logic [7:0]  LDN_B    = 8'h09,
  parameter logic [7:0]  LDN_C    = 8'h0A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic [2:0]  dev_act,
  output logic [47:0] dev_base
);
  localparam int NDEV = 3;

  logic        unl;
  logic [1:0]  kcnt;
  logic [7:0]  idx, ldn, key_b, rv;
  logic [NDEV-1:0] act;
  logic [15:0] base [NDEV];
  logic        hit;
  logic [1:0]  sel;

  wire iw = io_wr & ~io_addr;
  wire dw = io_wr & io_addr & unl;

  always_comb
    case (kcnt)
      2'd0:    key_b = 8'h87;
      2'd1:    key_b = 8'h01;
      default: key_b = 8'h55;
    endcase

  always_comb begin
    hit = 1'b1;
    sel = 2'd0;
    case (ldn)
      LDN_A:   sel = 2'd0;
      LDN_B:   sel = 2'd1;
      LDN_C:   sel = 2'd2;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unl  <= 1'b0;
      kcnt <= 2'd0;
      idx  <= 8'h00;
      ldn  <= 8'h00;
      act  <= '0;
      for (int i = 0; i < NDEV; i++) base[i] <= 16'h0000;
    end else begin
      if (iw) begin
        if (!unl) begin
          if (io_wdata == key_b) begin
            if (kcnt == 2'd3) begin
              unl  <= 1'b1;
              kcnt <= 2'd0;
            end else kcnt <= kcnt + 2'd1;
          end else kcnt <= (io_wdata == 8'h87) ? 2'd1 : 2'd0;
        end else idx <= io_wdata;
      end
      if (dw)
        case (idx)
          8'h02: if (io_wdata == 8'h02) unl <= 1'b0;
          8'h07: ldn <= io_wdata;
          8'h30: if (hit) act[sel] <= io_wdata[0];
          8'h60: if (hit) base[sel][15:8] <= io_wdata;
          8'h61: if (hit) base[sel][7:0]  <= io_wdata;
          default: ;
        endcase
    end
  end

  always_comb begin
    if (!unl)          rv = 8'hFF;
    else if (!io_addr) rv = idx;
    else
      case (idx)
        8'h07:   rv = ldn;
        8'h20:   rv = CHIP_ID[15:8];
        8'h21:   rv = CHIP_ID[7:0];
        8'h22:   rv = {4'h0, CHIP_REV};
        8'h30:   rv = hit ? {7'b0, act[sel]} : 8'h00;
        8'h60:   rv = hit ? base[sel][15:8] : 8'h00;
        8'h61:   rv = hit ? base[sel][7:0]  : 8'h00;
        default: rv = 8'h00;
      endcase
  end

  assign io_rdata = io_rd ? rv : 8'h00;
  assign dev_act  = act;

  for (genvar g = 0; g < NDEV; g++) begin : g_base
    assign dev_base[16*g +: 16] = base[g];
  end

  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl) |-> $past(iw && io_wdata == 8'h55 && kcnt == 2'd3));

  // R6
  exit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && idx == 8'h02 && io_wdata == 8'h02) |=> !unl);

  // R4
  locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl && io_wr && io_addr) |=> ($stable(dev_act) && $stable(dev_base) && $stable(ldn)));

  // R9
  act_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_act) |-> $past(dw && idx == 8'h30));

  // R7
  ldn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldn) |-> $past(dw && idx == 8'h07));
endmodule

// File: tb/sim_cfg_port_unlock.sv
`timescale 1ns/1ps
module sim_cfg_port_unlock;
  localparam logic [15:0] ID  = 16'hA5C3;
  localparam logic [3:0]  REV = 4'h3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [2:0]  dev_act;
  logic [47:0] dev_base;

  cfg_port_unlock u0 (.clk, .rst_n, .io_wr, .io_rd, .io_addr, .io_wdata,
                      .io_rdata, .dev_act, .dev_base);

  int nvec = 0, nerr = 0;

  bit          m_unl;
  int          m_cnt;
  logic [7:0]  m_idx, m_ldn;
  logic [2:0]  m_act;
  logic [47:0] m_base;

  task automatic chk(string r, logic [47:0] a, logic [47:0] e);
    nvec++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", r, a, e);
    end
  endtask

  function automatic int slot(logic [7:0] l);
    case (l)
      8'h07:   return 0;
      8'h09:   return 1;
      8'h0A:   return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(bit a);
    int s = slot(m_ldn);
    if (!m_unl) return 8'hFF;
    if (!a) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return ID[15:8];
      8'h21: return ID[7:0];
      8'h22: return {4'h0, REV};
      8'h30: return (s < 0) ? 8'h00 : {7'b0, m_act[s]};
      8'h60: return (s < 0) ? 8'h00 : m_base[16*s+8 +: 8];
      8'h61: return (s < 0) ? 8'h00 : m_base[16*s +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] key_at(int c);
    return (c == 0) ? 8'h87 : (c == 1) ? 8'h01 : 8'h55;
  endfunction

  task automatic model_wr(bit a, logic [7:0] d);
    int s = slot(m_ldn);
    if (!a) begin
      if (!m_unl) begin
        if (d == key_at(m_cnt)) begin
          if (m_cnt == 3) begin m_unl = 1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = (d == 8'h87) ? 1 : 0;
      end else m_idx = d;
    end else if (m_unl) begin
      case (m_idx)
        8'h02: if (d == 8'h02) begin m_unl = 0; m_cnt = 0; end
        8'h07: m_ldn = d;
        8'h30: if (s >= 0) m_act[s] = d[0];
        8'h60: if (s >= 0) m_base[16*s+8 +: 8] = d;
        8'h61: if (s >= 0) m_base[16*s +: 8] = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    model_wr(a, d);
    chk("R9 dev_act", {45'b0, dev_act}, {45'b0, m_act});
    chk("R10 dev_base", dev_base, m_base);
  endtask

  task automatic rd(bit a, string r);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #1 chk(r, {40'b0, io_rdata}, {40'b0, exp_rd(a)});
    @(negedge clk);
    io_rd = 1'b0;
    #1 chk("R12 idle", {40'b0, io_rdata}, 48'h0);
  endtask

  task automatic unlock();
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    m_unl = 0; m_cnt = 0; m_idx = 0; m_ldn = 0; m_act = 0; m_base = 0;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 act", {45'b0, dev_act}, 48'h0);
    chk("R1 base", dev_base, 48'h0);
    rd(1, "R1 locked read");
    // R4 locked writes ignored
    wr(1, 8'h55);
    rd(1, "R4 data read");
    rd(0, "R4 index read");
    // R3 wrong byte restarts
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h12);
    rd(1, "R3 still locked");
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
    rd(0, "R3 restart on 0x87 unlocks");
    rd(0, "R2 open");
    // R5 R8
    wr(0, 8'h20); rd(0, "R5 index readback"); rd(1, "R8 id hi");
    wr(0, 8'h21); rd(1, "R8 id lo");
    wr(0, 8'h22); rd(1, "R8 rev");
    // R7 R9 R10
    wr(0, 8'h07); wr(1, 8'h09); rd(1, "R7 ldn");
    wr(0, 8'h30); wr(1, 8'hFF); rd(1, "R9 act read");
    wr(0, 8'h60); wr(1, 8'h12); wr(0, 8'h61); wr(1, 8'h34); rd(1, "R10 base lo");
    wr(0, 8'h60); rd(1, "R10 base hi");
    wr(0, 8'h07); wr(1, 8'h0A);
    wr(0, 8'h30); wr(1, 8'h01); rd(1, "R9 bank C");
    // R11 unknown bank / index
    wr(0, 8'h07); wr(1, 8'h05);
    wr(0, 8'h30); wr(1, 8'h01); rd(1, "R11 act unknown bank");
    wr(0, 8'h60); wr(1, 8'hAB); rd(1, "R11 base unknown bank");
    wr(0, 8'h44); rd(1, "R11 empty index");
    // R6 exit
    wr(0, 8'h02); wr(1, 8'h05); rd(0, "R6 still open");
    wr(1, 8'h02); rd(1, "R6 relocked");
    wr(1, 8'h77); rd(0, "R4 after relock");
    unlock(); rd(0, "R2 reopen");

    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      int p  = $urandom_range(0, 4);
      logic [7:0] rb = 8'($urandom);
      logic [7:0] kb [5];
      logic [7:0] ib [5];
      logic [7:0] db [5];
      kb = '{8'h87, 8'h01, 8'h55, 8'h55, rb};
      ib = '{8'h02, 8'h07, 8'h30, 8'h60, (p[0] ? 8'h61 : 8'h20 + 8'(p))};
      db = '{8'h02, 8'h07, 8'h09, 8'h0A, rb};
      case (op)
        0, 1, 2: wr(0, kb[p]);
        3, 4:    wr(0, ib[p]);
        5, 6:    wr(1, db[p]);
        7:       rd(0, "R5 random index read");
        default: rd(1, "R11 random data read");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule